// File: doc/BRIEF.md
# Next Program-Counter and Link-Address Unit

This block owns the instruction address of a simple in-order core. It holds the current program counter in a register. Each cycle it works out the next address from a decoded flow selector, a 16-bit immediate, a 26-bit jump field and two register operands. The flow can be straight-line, a conditional branch, a pseudo-direct jump, or a jump through a register. The branch condition comes from a small comparator inside the block. That comparator tests the two operands for equality, or tests the first operand for being non-negative.

For jumps that link, the block also presents the return address and the number of the register that should receive it. The register file, the fetch path and the decoder sit outside this block. They use these outputs and the current PC directly. An enable input advances the PC. Synchronous reset loads the start address.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` is loaded with 0x0000_0000.
- R2: With `en` high and `flow` = 2'b00 (sequential), `pc` becomes `pc` + 4 at the edge.
- R3: With `flow` = 2'b01 (branch) and the condition true, the next `pc` is `pc` + 4 + (sign-extended `imm` × 4), so a negative immediate moves backward.
- R4: With `flow` = 2'b01 and the condition false, the next `pc` is `pc` + 4.
- R5: `cond` = 0 selects equality (`opa` == `opb`) and `cond` = 1 selects `opa` ≥ 0 as a signed value. `br_taken` shows that result whenever `flow` = 2'b01, and is 0 for every other flow.
- R6: With `flow` = 2'b10 (jump), the next `pc` is formed from bits 31:28 of `pc` + 4, then `jfield`, then two zero bits.
- R7: With `flow` = 2'b11 (register jump) and `opa[1:0]` = 0, the next `pc` is `opa`.
- R8: With `flow` = 2'b11 and `opa[1:0]` ≠ 0, `align_fault` is high and `pc` keeps its value across the edge.
- R9: `link_valid` is high exactly when `link` = 1 and `flow` is 2'b10 or 2'b11. `link_addr` always equals `pc` + 8. A `link` request on a sequential or branch flow is ignored.
- R10: `link_reg` is 31, except on a register jump with `dst_override` = 1, where it equals `dst_reg`.
- R11: With `en` low, `pc` does not change, whatever the flow inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the PC this cycle |
| flow | input | 2 | 00 sequential, 01 branch, 10 jump, 11 register jump |
| cond | input | 1 | Branch test: 0 equal, 1 greater-or-equal to zero |
| link | input | 1 | Jump writes a return address |
| dst_override | input | 1 | Register jump names its own link register |
| dst_reg | input | 5 | Link register used when overridden |
| imm | input | 16 | Signed word offset of a branch |
| jfield | input | 26 | Word address field of a jump |
| opa | input | 32 | First register operand / register-jump target |
| opb | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| br_taken | output | 1 | Branch condition result |
| align_fault | output | 1 | Register-jump target is not word aligned |
| link_valid | output | 1 | Return address is to be written |
| link_addr | output | 32 | Return address, PC + 8 |
| link_reg | output | 5 | Destination register for the return address |

## Verification
Branches are run with equal and unequal operands, with zero and with the most negative operand. This separates the two compare kinds from each other and shows whether the sign test looks at the top bit. Positive and negative immediates show whether the offset is sign-extended and word-scaled. A sequential step lands the PC at the last word of a 256 MB region. A jump from there must take its region bits from PC + 4 and not from PC, and a jump with an all-ones field checks that the field is not truncated. Register jumps with aligned and misaligned targets, with linking on and off, and with the destination overridden or not, exercise every link variant. A linking request on a branch shows that the request is ignored.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'b00,
        FLOW_BR   = 2'b01,
        FLOW_JMP  = 2'b10,
        FLOW_JREG = 2'b11
    } flow_e;

    localparam logic COND_EQ  = 1'b0;
    localparam logic COND_GEZ = 1'b1;
endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
    parameter int XLEN = 32
) (
    input  logic            cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            take
);
    import npc_pkg::*;

    always_comb begin
        if (cond == COND_GEZ) begin
            take = ~a[XLEN-1];
        end else begin
            take = (a == b);
        end
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int JF_W  = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [1:0]       flow,
    input  logic             take,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    input  logic [XLEN-1:0]  opa,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  ret_addr,
    output logic             misalign
);
    import npc_pkg::*;

    localparam int ALIGN_B = 2;
    localparam int EXT_W   = XLEN - IMM_W - ALIGN_B;
    localparam int REGION  = XLEN - JF_W - ALIGN_B;
    localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN_B);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    always_comb begin
        seq_pc   = pc + STEP;
        ret_addr = seq_pc + STEP;
        br_off   = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_B{1'b0}}};
        br_pc    = seq_pc + br_off;
        jmp_pc   = {seq_pc[XLEN-1 -: REGION], jfield, {ALIGN_B{1'b0}}};
        misalign = (flow == FLOW_JREG) && (opa[ALIGN_B-1:0] != '0);
        unique case (flow)
            FLOW_SEQ:  target = seq_pc;
            FLOW_BR:   target = take ? br_pc : seq_pc;
            FLOW_JMP:  target = jmp_pc;
            default:   target = opa;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int          XLEN     = 32,
    parameter int          IMM_W    = 16,
    parameter int          JF_W     = 26,
    parameter int          RA_W     = 5,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       flow,
    input  logic             cond,
    input  logic             link,
    input  logic             dst_override,
    input  logic [RA_W-1:0]  dst_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic [XLEN-1:0]  pc,
    output logic             br_taken,
    output logic             align_fault,
    output logic             link_valid,
    output logic [XLEN-1:0]  link_addr,
    output logic [RA_W-1:0]  link_reg
);
    import npc_pkg::*;

    localparam logic [RA_W-1:0] LINK_DEFAULT = {RA_W{1'b1}};
    localparam logic [XLEN-1:0] STEP         = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } npc_state_t;

    npc_state_t state_d, state_q;

    logic            cmp_take;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] ret;
    logic            mis;

    npc_cmp #(.XLEN(XLEN)) u_cmp (
        .cond (cond),
        .a    (opa),
        .b    (opb),
        .take (cmp_take)
    );

    npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JF_W(JF_W)) u_tgt (
        .pc       (state_q.pc),
        .flow     (flow),
        .take     (cmp_take),
        .imm      (imm),
        .jfield   (jfield),
        .opa      (opa),
        .target   (tgt),
        .ret_addr (ret),
        .misalign (mis)
    );

    always_comb begin
        state_d = state_q;
        if (en && !mis) begin
            state_d.pc = tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.pc <= XLEN'(RESET_PC);
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pc          = state_q.pc;
        br_taken    = (flow == FLOW_BR) && cmp_take;
        align_fault = mis;
        link_valid  = link && ((flow == FLOW_JMP) || (flow == FLOW_JREG));
        link_addr   = ret;
        link_reg    = ((flow == FLOW_JREG) && dst_override) ? dst_reg : LINK_DEFAULT;
    end

    // R2: a sequential step moves the PC forward by one word
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (en && flow == FLOW_SEQ) |=> (pc == $past(pc) + STEP));

    // R11: with the enable low the PC holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc));

    // R8: a misaligned register target leaves the PC untouched
    a_r8_fault_hold: assert property (@(posedge clk) disable iff (rst)
        align_fault |=> $stable(pc));

    // R7: an aligned register jump lands exactly on the operand
    a_r7_jreg: assert property (@(posedge clk) disable iff (rst)
        (en && flow == FLOW_JREG && !align_fault) |=> (pc == $past(opa)));

    // R9: the return address is two words past the PC
    a_r9_link: assert property (@(posedge clk) disable iff (rst)
        link_valid |-> (link_addr == pc + STEP + STEP));

    // R8: the PC never becomes misaligned
    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [1:0]  flow;
    logic        cond;
    logic        link;
    logic        dst_override;
    logic [4:0]  dst_reg;
    logic [15:0] imm;
    logic [25:0] jfield;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [31:0] pc;
    logic        br_taken;
    logic        align_fault;
    logic        link_valid;
    logic [31:0] link_addr;
    logic [4:0]  link_reg;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_pc;
    logic [31:0] q_pc[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst(rst), .en(en), .flow(flow), .cond(cond), .link(link),
        .dst_override(dst_override), .dst_reg(dst_reg), .imm(imm), .jfield(jfield),
        .opa(opa), .opb(opb), .pc(pc), .br_taken(br_taken), .align_fault(align_fault),
        .link_valid(link_valid), .link_addr(link_addr), .link_reg(link_reg)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: pops the expected PC after each edge
    always @(negedge clk) begin
        if (q_pc.size() > 0) begin
            logic [31:0] e;
            string t;
            e = q_pc.pop_front();
            t = q_tag.pop_front();
            chk(pc === e, t, pc, e);
        end
    end

    task automatic step(input logic e_en, input logic [1:0] f, input logic c,
                        input logic lk, input logic ov, input logic [4:0] dr,
                        input logic [15:0] im, input logic [25:0] jf,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
        logic        x_take, x_fault, x_lv;
        logic [31:0] x_next, p4;
        logic [4:0]  x_lr;
        @(negedge clk);
        en = e_en; flow = f; cond = c; link = lk; dst_override = ov; dst_reg = dr;
        imm = im; jfield = jf; opa = a; opb = b;
        #1;
        p4      = exp_pc + 32'd4;
        x_take  = (f == 2'b01) && (c ? (a[31] == 1'b0) : (a == b));
        x_fault = (f == 2'b11) && (a[1:0] != 2'b00);
        x_lv    = lk && (f[1] == 1'b1);
        x_lr    = (f == 2'b11 && ov) ? dr : 5'd31;
        case (f)
            2'b00:   x_next = p4;
            2'b01:   x_next = x_take ? p4 + ({{16{im[15]}}, im} << 2) : p4;
            2'b10:   x_next = {p4[31:28], jf, 2'b00};
            default: x_next = x_fault ? exp_pc : a;
        endcase
        if (!e_en) x_next = exp_pc;
        chk(br_taken === x_take, {tag, " R5 br_taken"}, 32'(br_taken), 32'(x_take));
        chk(align_fault === x_fault, {tag, " R8 align_fault"}, 32'(align_fault), 32'(x_fault));
        chk(link_valid === x_lv, {tag, " R9 link_valid"}, 32'(link_valid), 32'(x_lv));
        chk(link_addr === exp_pc + 32'd8, {tag, " R9 link_addr"}, link_addr, exp_pc + 32'd8);
        chk(link_reg === x_lr, {tag, " R10 link_reg"}, 32'(link_reg), 32'(x_lr));
        q_pc.push_back(x_next);
        q_tag.push_back({tag, " pc"});
        exp_pc = x_next;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; flow = 2'b00; cond = 1'b0; link = 1'b0;
        dst_override = 1'b0; dst_reg = 5'd0; imm = '0; jfield = '0; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(pc === 32'h0, "R1 reset pc", pc, 32'h0);
        exp_pc = 32'h0;

        step(1, 2'b00, 0, 0, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0, "R2 seq");
        step(1, 2'b00, 0, 1, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0, "R2 R9 seq link ignored");
        step(1, 2'b01, 0, 0, 0, 0, 16'h0005, 26'h0, 32'h1234, 32'h1234, "R3 R5 eq taken");
        step(1, 2'b01, 0, 0, 0, 0, 16'h0005, 26'h0, 32'h1234, 32'h1235, "R4 R5 eq not taken");
        step(1, 2'b01, 1, 0, 0, 0, 16'hFFFD, 26'h0, 32'h0, 32'h5, "R3 R5 gez zero backward");
        step(1, 2'b01, 1, 1, 0, 0, 16'hFFFD, 26'h0, 32'h8000_0000, 32'h0, "R4 R5 R9 gez negative");
        step(1, 2'b01, 1, 0, 0, 0, 16'h8000, 26'h0, 32'h7FFF_FFFF, 32'h0, "R3 most negative offset");
        step(0, 2'b10, 0, 1, 0, 0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, "R11 disabled jump");
        step(1, 2'b10, 0, 0, 0, 0, 16'h0, 26'h40, 32'h0, 32'h0, "R6 jump");
        step(1, 2'b11, 0, 1, 1, 5'd7, 16'h0, 26'h0, 32'h0FFF_FFF8, 32'h0, "R7 R9 R10 jreg override");
        step(1, 2'b00, 0, 0, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0, "R2 seq to region end");
        step(1, 2'b10, 0, 1, 1, 5'd3, 16'h0, 26'h3, 32'h0, 32'h0, "R6 R9 R10 jump across region");
        step(1, 2'b10, 0, 0, 0, 0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, "R6 jump full field");
        step(1, 2'b11, 0, 1, 0, 5'd9, 16'h0, 26'h0, 32'h0000_0202, 32'h0, "R8 misaligned jreg");
        step(1, 2'b11, 0, 1, 0, 5'd9, 16'h0, 26'h0, 32'h0000_0200, 32'h0, "R7 R10 jreg default reg");
        step(1, 2'b01, 0, 1, 1, 5'd4, 16'h0010, 26'h0, 32'h7, 32'h7, "R3 R9 R10 branch link ignored");
        step(1, 2'b00, 0, 0, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0, "R2 final seq");
        @(negedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule